// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves data between system memory and a card data FIFO by following a linked set of 16-byte descriptors held in memory. Software writes the address of the first descriptor, picks a direction and sets the enable bit. The engine then reads each descriptor and checks that the ownership flag hands the descriptor to it. It moves the described buffer one 32-bit word at a time, writes the flag word back with ownership returned to software, and moves on to the next descriptor. The next descriptor is found through an explicit link, by wrapping to the base, or by stepping to the next slot.

Each descriptor has four words. Word 0 holds the flags:
- bit 31: engine owns the descriptor.
- bit 30: card error seen.
- bit 5: wrap to base.
- bit 4: follow link.
- bit 3: first.
- bit 2: last.
- bit 1: suppress completion.

Word 1 holds the byte count in its low SIZE_BITS bits. Word 2 is the buffer address and word 3 is the link address. A status register shows sticky event bits, two summary bits and the current engine state code. An interrupt-enable register selects which status bits drive the interrupt line.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the status reads 0 (state code 0, idle), the control register reads 0, irq is low and no memory request is issued.
- R2: The register port decodes address 0 as control, 1 as descriptor base, 2 as status and 3 as interrupt enable. In the control register, bit 1 (fixed burst) and bit 4 (direction, 1 = memory to FIFO) are stored and read back, and bit 7 reads back the enable. Writing bit 7 = 1 with bit 0 = 0 while idle starts a walk at the base address. The engine reads the four descriptor words in ascending order, and a memory request holds its address until it is acknowledged.
- R3: A fetched descriptor with bit 31 = 0 causes no buffer access and is not written back. It sets status bit 4 and leaves the engine suspended (state code 1). A later write with enable set fetches that same descriptor again.
- R4: The buffer byte count is word 1 bits [SIZE_BITS-1:0], and a count of 0 means 2^SIZE_BITS bytes. Exactly count/4 words are moved, with nothing beyond them.
- R5: With direction 1, buffer words are read at ascending addresses and pushed to the FIFO in that order. No push happens while fifo_full is high.
- R6: With direction 0, words are popped only while fifo_empty is low and are written to ascending buffer addresses.
- R7: After its buffer, a descriptor's word 0 is written back with bit 31 cleared. Bit 30 is set if a card error occurred during that descriptor, and all other bits are kept.
- R8: The next descriptor address is word 3 when bit 4 is set. Otherwise it is the base address when bit 5 is set, and otherwise the current address plus 16.
- R9: After writing back a descriptor with bit 2 set, the engine sets status bit 0 (direction 1) or bit 1 (direction 0) unless flag bit 1 is set. It then returns to idle and clears the enable.
- R10: A memory acknowledge with mem_err sets status bit 2, stops the engine at idle and clears the enable, leaving the descriptor open.
- R11: Status bit 8 is the OR of bits 0 and 1, bit 9 is the OR of bits 2, 4 and 5, and bits 16:13 give the state code (0 idle to 8 write-back). Writing ones to bits 0, 1, 2, 4 and 5 clears them, and writing zeros leaves them alone.
- R12: irq is high exactly when some status bit in 9:0 is set together with the same bit of the interrupt-enable register.
- R13: Writing control bit 0 returns the engine to idle at once and clears the enable, leaving the sticky status bits unchanged.
- R14: A card_err pulse while a buffer is being moved sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Completed request failed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| fifo_push | output | 1 | Push a word towards the card |
| fifo_wdata | output | 32 | Word pushed |
| fifo_full | input | 1 | Card-bound FIFO cannot accept |
| fifo_pop | output | 1 | Pop a word from the card |
| fifo_rdata | input | 32 | Head word of the card-side FIFO |
| fifo_empty | input | 1 | Card-side FIFO has no word |
| card_err | input | 1 | Card reported an error |

## Verification
Single descriptors are swept over every buffer length of a small configuration, in both directions, with memory and FIFO back-pressure both off and on. Running the same lengths with and without stalls shows whether word counts and ordering hold when handshakes wait. A three-descriptor linked chain, a consecutive-slot pair and a wrap-to-base ring whose second visit finds a released descriptor tell apart the three ways of finding the next descriptor. They also show that suspension and resumption work on the same descriptor. Separate runs with a foreign-owned descriptor, an injected bus error, a suppressed completion, a card error and a soft reset under a blocked FIFO exercise the status, clearing and interrupt gating.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_SUSP = 4'd1,
        ST_DRD  = 4'd2,
        ST_DCHK = 4'd3,
        ST_RDW  = 4'd4,
        ST_WRW  = 4'd5,
        ST_RD   = 4'd6,
        ST_WR   = 4'd7,
        ST_DCLS = 4'd8
    } dstate_e;

    // descriptor flag word bit positions
    localparam int F_OWN  = 31;
    localparam int F_CES  = 30;
    localparam int F_WRAP = 5;
    localparam int F_LINK = 4;
    localparam int F_LAST = 2;
    localparam int F_NOCP = 1;

    // register select codes
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_BASE = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_IEN  = 2'd3;

    // sticky status bits that exist (bit 3 is reserved)
    localparam logic [5:0] STAT_MASK = 6'b110111;

endpackage

// File: rtl/dcd_regs.sv
module dcd_regs
    import dma_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [3:0]  state_i,
    input  logic        ev_tx_i,
    input  logic        ev_rx_i,
    input  logic        ev_bus_i,
    input  logic        ev_unav_i,
    input  logic        ev_card_i,
    input  logic        halt_i,
    output logic        go_o,
    output logic        srst_o,
    output logic        tx_o,
    output logic [31:0] base_o,
    output logic        irq_o
);

    typedef struct packed {
        logic        en;
        logic        fixb;
        logic        tx;
        logic [31:0] base;
        logic [5:0]  stat;
        logic [9:0]  ien;
    } regs_s;

    regs_s reg_d, reg_q;
    logic        ctrl_wr;
    logic [31:0] stat_view;

    always_comb begin
        reg_d   = reg_q;
        ctrl_wr = cfg_we && (cfg_addr == RA_CTRL);
        if (ctrl_wr) begin
            reg_d.en   = cfg_wdata[7] & ~cfg_wdata[0];
            reg_d.fixb = cfg_wdata[1];
            reg_d.tx   = cfg_wdata[4];
        end else if (halt_i) begin
            reg_d.en = 1'b0;
        end
        if (cfg_we && (cfg_addr == RA_BASE)) reg_d.base = cfg_wdata;
        if (cfg_we && (cfg_addr == RA_IEN))  reg_d.ien  = cfg_wdata[9:0];
        if (cfg_we && (cfg_addr == RA_STAT))
            reg_d.stat = reg_q.stat & ~(cfg_wdata[5:0] & STAT_MASK);
        // new events win over a simultaneous clear
        reg_d.stat = reg_d.stat | {ev_card_i, ev_unav_i, 1'b0, ev_bus_i, ev_rx_i, ev_tx_i};

        stat_view        = 32'd0;
        stat_view[5:0]   = reg_q.stat;
        stat_view[8]     = reg_q.stat[0] | reg_q.stat[1];
        stat_view[9]     = reg_q.stat[2] | reg_q.stat[4] | reg_q.stat[5];
        stat_view[16:13] = state_i;

        case (cfg_addr)
            RA_CTRL: cfg_rdata = {24'd0, reg_q.en, 2'b00, reg_q.tx, 2'b00, reg_q.fixb, 1'b0};
            RA_BASE: cfg_rdata = reg_q.base;
            RA_STAT: cfg_rdata = stat_view;
            default: cfg_rdata = {22'd0, reg_q.ien};
        endcase
    end

    assign go_o   = ctrl_wr && cfg_wdata[7] && !cfg_wdata[0];
    assign srst_o = ctrl_wr && cfg_wdata[0];
    assign tx_o   = reg_q.tx;
    assign base_o = reg_q.base;
    assign irq_o  = |(stat_view[9:0] & reg_q.ien);

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    // completion or fault drops the enable unless software rewrites control
    assert_halt_drops_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !ctrl_wr) |=> !reg_q.en);

    // a one written to a sticky bit clears it when no new event arrives
    assert_w1c_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == RA_STAT && cfg_wdata[0] && !ev_tx_i) |=> !reg_q.stat[0]);

    // soft reset leaves the engine disabled
    assert_srst_disables_R13: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !reg_q.en);

endmodule

// File: rtl/dcd_walker.sv
module dcd_walker
    import dma_chain_pkg::*;
#(
    parameter int SIZE_BITS = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic        srst_i,
    input  logic        tx_i,
    input  logic [31:0] base_i,
    input  logic        card_err_i,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    output logic        fifo_push,
    output logic [31:0] fifo_wdata,
    input  logic        fifo_full,
    output logic        fifo_pop,
    input  logic [31:0] fifo_rdata,
    input  logic        fifo_empty,
    output logic [3:0]  state_o,
    output logic        ev_tx_o,
    output logic        ev_rx_o,
    output logic        ev_bus_o,
    output logic        ev_unav_o,
    output logic        ev_card_o,
    output logic        halt_o
);

    localparam int REM_W = SIZE_BITS + 1;

    typedef struct packed {
        dstate_e              st;
        logic [1:0]           widx;
        logic [31:0]          cur;
        logic [31:0]          w0;
        logic [SIZE_BITS-1:0] sz;
        logic [31:0]          w2;
        logic [31:0]          w3;
        logic [REM_W-1:0]     rem;
        logic [31:0]          ptr;
        logic [31:0]          data;
        logic                 ces;
    } walk_s;

    walk_s wk_d, wk_q;
    logic  moving;

    always_comb begin
        wk_d       = wk_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = wk_q.ptr;
        mem_wdata  = wk_q.data;
        fifo_push  = 1'b0;
        fifo_pop   = 1'b0;
        ev_tx_o    = 1'b0;
        ev_rx_o    = 1'b0;
        ev_bus_o   = 1'b0;
        ev_unav_o  = 1'b0;
        halt_o     = 1'b0;
        moving     = (wk_q.st == ST_RDW) || (wk_q.st == ST_WRW) ||
                     (wk_q.st == ST_RD)  || (wk_q.st == ST_WR);

        case (wk_q.st)
            ST_IDLE: if (go_i) begin
                wk_d.cur  = base_i;
                wk_d.widx = 2'd0;
                wk_d.st   = ST_DRD;
            end
            ST_SUSP: if (go_i) begin
                wk_d.widx = 2'd0;
                wk_d.st   = ST_DRD;
            end
            ST_DRD: begin
                mem_req  = 1'b1;
                mem_addr = wk_q.cur + 32'({wk_q.widx, 2'b00});
                if (mem_ack) begin
                    if (mem_err) begin
                        ev_bus_o = 1'b1;
                        halt_o   = 1'b1;
                        wk_d.st  = ST_IDLE;
                    end else begin
                        case (wk_q.widx)
                            2'd0:    wk_d.w0 = mem_rdata;
                            2'd1:    wk_d.sz = mem_rdata[SIZE_BITS-1:0];
                            2'd2:    wk_d.w2 = mem_rdata;
                            default: wk_d.w3 = mem_rdata;
                        endcase
                        wk_d.widx = wk_q.widx + 2'd1;
                        if (wk_q.widx == 2'd3) wk_d.st = ST_DCHK;
                    end
                end
            end
            ST_DCHK: begin
                if (!wk_q.w0[F_OWN]) begin
                    ev_unav_o = 1'b1;
                    wk_d.st   = ST_SUSP;
                end else begin
                    wk_d.rem = (wk_q.sz == '0) ? (REM_W'(1) << SIZE_BITS) : {1'b0, wk_q.sz};
                    wk_d.ptr = wk_q.w2;
                    wk_d.ces = 1'b0;
                    wk_d.st  = tx_i ? ST_RDW : ST_WRW;
                end
            end
            ST_RDW: if (!fifo_full) wk_d.st = ST_RD;
            ST_RD: begin
                mem_req  = !fifo_full;
                mem_addr = wk_q.ptr;
                if (mem_req && mem_ack) begin
                    if (mem_err) begin
                        ev_bus_o = 1'b1;
                        halt_o   = 1'b1;
                        wk_d.st  = ST_IDLE;
                    end else begin
                        fifo_push = 1'b1;
                        wk_d.ptr  = wk_q.ptr + 32'd4;
                        wk_d.rem  = wk_q.rem - REM_W'(4);
                        wk_d.st   = (wk_q.rem <= REM_W'(4)) ? ST_DCLS : ST_RDW;
                    end
                end
            end
            ST_WRW: if (!fifo_empty) begin
                fifo_pop  = 1'b1;
                wk_d.data = fifo_rdata;
                wk_d.st   = ST_WR;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wk_q.ptr;
                mem_wdata = wk_q.data;
                if (mem_ack) begin
                    if (mem_err) begin
                        ev_bus_o = 1'b1;
                        halt_o   = 1'b1;
                        wk_d.st  = ST_IDLE;
                    end else begin
                        wk_d.ptr = wk_q.ptr + 32'd4;
                        wk_d.rem = wk_q.rem - REM_W'(4);
                        wk_d.st  = (wk_q.rem <= REM_W'(4)) ? ST_DCLS : ST_WRW;
                    end
                end
            end
            ST_DCLS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wk_q.cur;
                mem_wdata = {1'b0, wk_q.w0[F_CES] | wk_q.ces, wk_q.w0[29:0]};
                if (mem_ack) begin
                    if (mem_err) begin
                        ev_bus_o = 1'b1;
                        halt_o   = 1'b1;
                        wk_d.st  = ST_IDLE;
                    end else if (wk_q.w0[F_LAST]) begin
                        ev_tx_o = tx_i && !wk_q.w0[F_NOCP];
                        ev_rx_o = !tx_i && !wk_q.w0[F_NOCP];
                        halt_o  = 1'b1;
                        wk_d.st = ST_IDLE;
                    end else begin
                        if (wk_q.w0[F_LINK])      wk_d.cur = wk_q.w3;
                        else if (wk_q.w0[F_WRAP]) wk_d.cur = base_i;
                        else                      wk_d.cur = wk_q.cur + 32'd16;
                        wk_d.widx = 2'd0;
                        wk_d.st   = ST_DRD;
                    end
                end
            end
            default: wk_d.st = ST_IDLE;
        endcase

        if (moving && card_err_i) wk_d.ces = 1'b1;
        if (srst_i) wk_d.st = ST_IDLE;
    end

    assign fifo_wdata = mem_rdata;
    assign ev_card_o  = moving && card_err_i;
    assign state_o    = wk_q.st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q    <= '0;
            wk_q.st <= ST_IDLE;
        end else begin
            wk_q <= wk_d;
        end
    end

    assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    assert_pop_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !srst_i && wk_q.st != ST_RD) |=> (mem_req && $stable(mem_addr)));

    assert_unav_suspends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_unav_o && !srst_i) |=> (wk_q.st == ST_SUSP));

    assert_state_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wk_q.st <= ST_DCLS);

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
    parameter int SIZE_BITS = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    output logic        fifo_push,
    output logic [31:0] fifo_wdata,
    input  logic        fifo_full,
    output logic        fifo_pop,
    input  logic [31:0] fifo_rdata,
    input  logic        fifo_empty,
    input  logic        card_err
);

    logic        go, srst, tx, halt;
    logic        ev_tx, ev_rx, ev_bus, ev_unav, ev_card;
    logic [31:0] base;
    logic [3:0]  state;

    dcd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .state_i   (state),
        .ev_tx_i   (ev_tx),
        .ev_rx_i   (ev_rx),
        .ev_bus_i  (ev_bus),
        .ev_unav_i (ev_unav),
        .ev_card_i (ev_card),
        .halt_i    (halt),
        .go_o      (go),
        .srst_o    (srst),
        .tx_o      (tx),
        .base_o    (base),
        .irq_o     (irq)
    );

    dcd_walker #(.SIZE_BITS(SIZE_BITS)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .srst_i     (srst),
        .tx_i       (tx),
        .base_i     (base),
        .card_err_i (card_err),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .fifo_full  (fifo_full),
        .fifo_pop   (fifo_pop),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (fifo_empty),
        .state_o    (state),
        .ev_tx_o    (ev_tx),
        .ev_rx_o    (ev_rx),
        .ev_bus_o   (ev_bus),
        .ev_unav_o  (ev_unav),
        .ev_card_o  (ev_card),
        .halt_o     (halt)
    );

endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;

    localparam int SB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [31:0] fifo_wdata, fifo_rdata;
    logic        card_err = 1'b0;

    logic        stall = 1'b0;
    logic        hold_full = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = 32'd0;
    int          cyc = 0;
    int          txn = 0;
    int          rxn = 0;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] mem [0:255];
    logic [31:0] txlog [0:255];

    always #4 clk = ~clk;

    dma_chain_engine #(.SIZE_BITS(SB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_full(fifo_full), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
        .fifo_empty(fifo_empty), .card_err(card_err)
    );

    // memory and FIFO models
    always @(negedge clk) cyc <= cyc + 1;
    assign mem_ack    = mem_req && (!stall || (cyc % 3 != 0));
    assign mem_err    = mem_ack && err_en && (mem_addr == err_addr);
    assign mem_rdata  = mem[mem_addr[9:2]];
    assign fifo_full  = hold_full || (stall && (cyc % 4 == 1));
    assign fifo_empty = stall && (cyc % 4 == 2);
    assign fifo_rdata = 32'hA500_0000 + 32'(rxn);

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
        if (fifo_push) begin
            txlog[txn[7:0]] <= fifo_wdata;
            txn <= txn + 1;
        end
        if (fifo_pop) rxn <= rxn + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] s;
        int n = 0;
        do begin
            @(negedge clk);
            reg_rd(2'd2, s);
            n++;
        end while (s[16:13] > 4'd1 && n < 3000);
    endtask

    task automatic start(input logic [31:0] base, input bit tx);
        reg_wr(2'd0, 32'h1);
        reg_wr(2'd1, base);
        reg_wr(2'd0, 32'h80 | (32'(tx) << 4));
    endtask

    task automatic put_desc(input int a, input logic [31:0] f, input logic [31:0] sz,
                            input logic [31:0] buf_a, input logic [31:0] nxt);
        mem[a/4] = f; mem[a/4 + 1] = sz; mem[a/4 + 2] = buf_a; mem[a/4 + 3] = nxt;
    endtask

    initial begin
        logic [31:0] r;
        int t0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(2'd2, r); chk("R1 status", r, 32'h0);
        reg_rd(2'd0, r); chk("R1 ctrl", r, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 no request", 32'(mem_req), 32'h0);

        // R2 control fields read back without starting
        reg_wr(2'd0, 32'h12);
        reg_rd(2'd0, r); chk("R2 ctrl readback", r, 32'h12);
        reg_rd(2'd2, r); chk("R2 still idle", r, 32'h0);

        // sweep: direction x length x back-pressure (R2 R4 R5 R6 R7 R9 R11)
        for (int dir = 0; dir < 2; dir++) begin
            for (int s = 1; s <= 4; s++) begin
                for (int st = 0; st < 2; st++) begin
                    stall = st[0];
                    put_desc(32'h40, 32'h8000_000C, (s == 4) ? 32'd0 : 32'(4 * s),
                             (dir == 1) ? 32'h100 : 32'h200, 32'h0);
                    for (int i = 0; i < 5; i++) begin
                        mem[64 + i]  = 32'h1000_0000 + 32'(dir * 256 + s * 16 + i);
                        mem[128 + i] = 32'h0;
                    end
                    reg_wr(2'd2, 32'h3F);
                    t0 = txn; r0 = rxn;
                    start(32'h40, dir[0]);
                    wait_stop();
                    reg_rd(2'd2, r);
                    chk("R9 R11 done status", r, (dir == 1) ? 32'h101 : 32'h102);
                    reg_rd(2'd0, r);
                    chk("R9 enable cleared", r, 32'(dir) << 4);
                    chk("R7 closed flags", mem[16], 32'h0000_000C);
                    if (dir == 1) begin
                        chk("R4 tx word count", 32'(txn - t0), 32'(s));
                        for (int i = 0; i < s; i++)
                            chk("R5 tx data order", txlog[(t0 + i) % 256],
                                32'h1000_0000 + 32'(256 + s * 16 + i));
                    end else begin
                        chk("R4 rx word count", 32'(rxn - r0), 32'(s));
                        for (int i = 0; i < s; i++)
                            chk("R6 rx data order", mem[128 + i], 32'hA500_0000 + 32'(r0 + i));
                        chk("R4 no overrun", mem[128 + s], 32'h0);
                    end
                end
            end
        end
        stall = 1'b0;

        // R8 linked chain of three, sizes 8, max, 4
        put_desc(32'h00, 32'h8000_0018, 32'd8, 32'h100, 32'h80);
        put_desc(32'h80, 32'h8000_0010, 32'd0, 32'h120, 32'h40);
        put_desc(32'h40, 32'h8000_0004, 32'd4, 32'h140, 32'h0);
        for (int i = 0; i < 24; i++) mem[64 + i] = 32'h2000_0000 + 32'(i);
        reg_wr(2'd2, 32'h3F);
        t0 = txn;
        start(32'h00, 1'b1);
        wait_stop();
        chk("R8 chain word count", 32'(txn - t0), 32'd7);
        chk("R8 chain w0", txlog[(t0 + 0) % 256], 32'h2000_0000);
        chk("R8 chain w1", txlog[(t0 + 1) % 256], 32'h2000_0001);
        for (int i = 0; i < 4; i++)
            chk("R8 chain second buffer", txlog[(t0 + 2 + i) % 256], 32'h2000_0008 + 32'(i));
        chk("R8 chain third buffer", txlog[(t0 + 6) % 256], 32'h2000_0010);
        chk("R7 chain close 0", mem[0], 32'h18);
        chk("R7 chain close 1", mem[32], 32'h10);
        chk("R7 chain close 2", mem[16], 32'h04);

        // R8 consecutive slots
        put_desc(32'hC0, 32'h8000_0000, 32'd4, 32'h100, 32'h3FC);
        put_desc(32'hD0, 32'h8000_0004, 32'd4, 32'h104, 32'h0);
        t0 = txn;
        start(32'hC0, 1'b1);
        wait_stop();
        chk("R8 sequential count", 32'(txn - t0), 32'd2);
        chk("R8 sequential second", txlog[(t0 + 1) % 256], 32'h2000_0001);

        // R8 R3 ring wraps to base and finds a released descriptor
        put_desc(32'hE0, 32'h8000_0020, 32'd4, 32'h108, 32'h0);
        reg_wr(2'd2, 32'h3F);
        t0 = txn;
        start(32'hE0, 1'b1);
        wait_stop();
        reg_rd(2'd2, r); chk("R3 ring suspends", r, 32'h2210);
        chk("R8 ring one word", 32'(txn - t0), 32'd1);
        chk("R7 ring closed", mem[56], 32'h20);
        mem[56] = 32'h8000_0024;
        reg_wr(2'd0, 32'h90);
        wait_stop();
        reg_rd(2'd2, r); chk("R3 resume completes", r, 32'h311);
        chk("R3 resume same descriptor", 32'(txn - t0), 32'd2);

        // R3 foreign-owned descriptor at start
        put_desc(32'h40, 32'h0000_000C, 32'd4, 32'h100, 32'h0);
        reg_wr(2'd2, 32'h3F);
        t0 = txn;
        start(32'h40, 1'b1);
        wait_stop();
        reg_rd(2'd2, r); chk("R3 unavailable status", r, 32'h2210);
        chk("R3 no transfer", 32'(txn - t0), 32'd0);
        chk("R3 not written back", mem[16], 32'h0000_000C);

        // R10 bus error on second buffer word
        put_desc(32'h40, 32'h8000_0004, 32'd8, 32'h100, 32'h0);
        reg_wr(2'd2, 32'h3F);
        err_en = 1'b1; err_addr = 32'h104;
        t0 = txn;
        start(32'h40, 1'b1);
        wait_stop();
        err_en = 1'b0;
        reg_rd(2'd2, r); chk("R10 fault status", r, 32'h204);
        reg_rd(2'd0, r); chk("R10 enable cleared", r, 32'h10);
        chk("R10 words before fault", 32'(txn - t0), 32'd1);
        chk("R10 descriptor left open", mem[16], 32'h8000_0004);

        // R12 interrupt gating and R11 write-one-to-clear
        reg_wr(2'd3, 32'h0);    @(negedge clk); chk("R12 all masked", 32'(irq), 32'h0);
        reg_wr(2'd3, 32'h4);    @(negedge clk); chk("R12 bus bit enabled", 32'(irq), 32'h1);
        reg_wr(2'd3, 32'h200);  @(negedge clk); chk("R12 abnormal summary", 32'(irq), 32'h1);
        reg_wr(2'd3, 32'h100);  @(negedge clk); chk("R12 normal summary idle", 32'(irq), 32'h0);
        reg_wr(2'd2, 32'h1);
        reg_rd(2'd2, r); chk("R11 clear of unset bit", r, 32'h204);
        reg_wr(2'd2, 32'h0);
        reg_rd(2'd2, r); chk("R11 zeros keep bits", r, 32'h204);
        reg_wr(2'd2, 32'h4);
        reg_rd(2'd2, r); chk("R11 ones clear bit", r, 32'h0);
        reg_wr(2'd3, 32'h0);

        // R9 suppressed completion
        put_desc(32'h40, 32'h8000_0006, 32'd4, 32'h100, 32'h0);
        start(32'h40, 1'b1);
        wait_stop();
        reg_rd(2'd2, r); chk("R9 no done when suppressed", r, 32'h0);
        chk("R7 suppressed close", mem[16], 32'h6);

        // R14 card error during receive
        put_desc(32'h40, 32'h8000_0004, 32'd0, 32'h200, 32'h0);
        stall = 1'b1;
        start(32'h40, 1'b0);
        begin
            int n = 0;
            do begin @(negedge clk); reg_rd(2'd2, r); n++; end
            while (r[16:13] != 4'd5 && n < 500);
        end
        card_err = 1'b1;
        @(negedge clk);
        card_err = 1'b0;
        wait_stop();
        stall = 1'b0;
        reg_rd(2'd2, r); chk("R14 card error status", r, 32'h322);
        chk("R7 card error flag", mem[16], 32'h4000_0004);

        // R13 soft reset while blocked on a full FIFO
        put_desc(32'h40, 32'h8000_0004, 32'd4, 32'h100, 32'h0);
        hold_full = 1'b1;
        t0 = txn;
        start(32'h40, 1'b1);
        repeat (10) @(negedge clk);
        reg_rd(2'd2, r); chk("R5 waits on full FIFO", 32'(r[16:13]), 32'd4);
        reg_wr(2'd0, 32'h1);
        reg_rd(2'd2, r); chk("R13 idle, status kept", r, 32'h322);
        reg_rd(2'd0, r); chk("R13 enable cleared", r, 32'h0);
        hold_full = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 no push while full", 32'(txn - t0), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule